// File: doc/BRIEF.md
# Obstacle-Alternating Turn Controller

This block is a small synchronous Mealy state machine that steers a mobile robot. The robot drives straight while its path is clear. When a one-bit obstacle input goes high, the block commands a turn and holds that command until the obstacle input falls again. It alternates the turn direction from one obstacle to the next. To do that it keeps two state bits that record whether it is turning now and which way it turned last.

The action output is combinational from the obstacle input and the registered state, so a new obstacle is answered in the same cycle it appears. The state moves on at each rising clock edge. A synchronous, active-high clear returns the machine to the clear-path state that counts the last turn as a left turn, so the first obstacle after clear gives a right turn. The present-state code is driven onto a port so that each transition can be observed directly.

Top module: `turn_alternator`

## Requirements
- R1: While `rst` is high at a rising edge, `state_o` becomes 2'b00 after that edge. This holds whatever the value of `obstacle_i`.
- R2: From state 2'b00 (clear, last turn left), an edge with `obstacle_i`=0 keeps the state at 2'b00, and an edge with `obstacle_i`=1 moves it to 2'b01.
- R3: From state 2'b01 (turning right), an edge with `obstacle_i`=0 moves the state to 2'b11, and an edge with `obstacle_i`=1 keeps it at 2'b01.
- R4: From state 2'b11 (clear, last turn right), an edge with `obstacle_i`=0 keeps the state at 2'b11, and an edge with `obstacle_i`=1 moves it to 2'b10.
- R5: From state 2'b10 (turning left), an edge with `obstacle_i`=0 moves the state to 2'b00, and an edge with `obstacle_i`=1 keeps it at 2'b10.
- R6: `action_o` is 2'b00 (no turn) when `obstacle_i`=0. When `obstacle_i`=1 it is 2'b01 (turn right) if `state_o[1]`=0 and 2'b10 (turn left) if `state_o[1]`=1. The value 2'b11 never appears.
- R7: `action_o` follows a change of `obstacle_i` within the same clock cycle, with no clock edge in between.
- R8: Two obstacle episodes separated by at least one clear cycle get opposite turn directions: a right turn is followed by a left turn, and a left turn by a right turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear to state 2'b00 |
| obstacle_i | input | 1 | 1 when an obstacle is ahead, 0 when the path is clear |
| action_o | output | 2 | 00 no turn, 01 turn right, 10 turn left |
| state_o | output | 2 | Present state code |

## Verification
The bench puts the machine into each of the four states, applies both obstacle values, and compares both the immediate action and the next state with a table model. A wrong state code would show up as a bad successor. A registered output would answer the mid-cycle obstacle change one cycle late. The bench also holds clear high together with an obstacle, which catches a clear that obstacle overrides. Finally it runs back-to-back obstacle episodes, including single-cycle ones, which catches a machine that forgets the last direction or goes back to the turning state without alternating.

// File: rtl/turn_pkg.sv
package turn_pkg;
    localparam int STATE_W  = 2;
    localparam int ACTION_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_CLEAR_LAST_LEFT  = 2'b00,
        ST_TURN_RIGHT       = 2'b01,
        ST_CLEAR_LAST_RIGHT = 2'b11,
        ST_TURN_LEFT        = 2'b10
    } turn_state_t;

    localparam logic [ACTION_W-1:0] ACT_NONE  = 2'b00;
    localparam logic [ACTION_W-1:0] ACT_RIGHT = 2'b01;
    localparam logic [ACTION_W-1:0] ACT_LEFT  = 2'b10;

    typedef struct packed {
        turn_state_t st;
    } turn_regs_t;
endpackage

// File: rtl/turn_next_state.sv
module turn_next_state
    import turn_pkg::*;
(
    input  turn_state_t cur_i,
    input  logic        obstacle_i,
    output turn_state_t nxt_o
);
    always_comb begin
        unique case (cur_i)
            ST_CLEAR_LAST_LEFT:  nxt_o = obstacle_i ? ST_TURN_RIGHT : ST_CLEAR_LAST_LEFT;
            ST_TURN_RIGHT:       nxt_o = obstacle_i ? ST_TURN_RIGHT : ST_CLEAR_LAST_RIGHT;
            ST_CLEAR_LAST_RIGHT: nxt_o = obstacle_i ? ST_TURN_LEFT  : ST_CLEAR_LAST_RIGHT;
            ST_TURN_LEFT:        nxt_o = obstacle_i ? ST_TURN_LEFT  : ST_CLEAR_LAST_LEFT;
            default:             nxt_o = ST_CLEAR_LAST_LEFT;
        endcase
    end
endmodule

// File: rtl/turn_action_decode.sv
module turn_action_decode
    import turn_pkg::*;
(
    input  turn_state_t          cur_i,
    input  logic                 obstacle_i,
    output logic [ACTION_W-1:0]  action_o
);
    // The upper state bit says which way the next turn must go.
    logic go_left;
    assign go_left = cur_i[STATE_W-1];

    always_comb begin
        if (!obstacle_i)
            action_o = ACT_NONE;
        else if (go_left)
            action_o = ACT_LEFT;
        else
            action_o = ACT_RIGHT;
    end
endmodule

// File: rtl/turn_alternator.sv
module turn_alternator
    import turn_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                obstacle_i,
    output logic [ACTION_W-1:0] action_o,
    output logic [STATE_W-1:0]  state_o
);
    turn_regs_t  regs_d, regs_q;
    turn_state_t step_st;

    turn_next_state u_next (
        .cur_i      (regs_q.st),
        .obstacle_i (obstacle_i),
        .nxt_o      (step_st)
    );

    turn_action_decode u_act (
        .cur_i      (regs_q.st),
        .obstacle_i (obstacle_i),
        .action_o   (action_o)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst)
            regs_d.st = ST_CLEAR_LAST_LEFT;
        else
            regs_d.st = step_st;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign state_o = regs_q.st;
endmodule

// File: rtl/turn_alternator_checker.sv
module turn_alternator_checker (
    input logic       clk,
    input logic       rst,
    input logic       obstacle_i,
    input logic [1:0] action_o,
    input logic [1:0] state_o
);
    p_clear_r1: assert property (@(posedge clk) rst |=> state_o == 2'b00);

    p_from_a_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00) |=> state_o == ($past(obstacle_i) ? 2'b01 : 2'b00));

    p_from_b_r3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01) |=> state_o == ($past(obstacle_i) ? 2'b01 : 2'b11));

    p_from_c_r4: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b11) |=> state_o == ($past(obstacle_i) ? 2'b10 : 2'b11));

    p_from_d_r5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b10) |=> state_o == ($past(obstacle_i) ? 2'b10 : 2'b00));

    p_idle_action_r6: assert property (@(posedge clk) disable iff (rst)
        !obstacle_i |-> action_o == 2'b00);

    p_no_code3_r6: assert property (@(posedge clk) disable iff (rst)
        action_o != 2'b11);

    p_one_turn_r6: assert property (@(posedge clk) disable iff (rst)
        obstacle_i |-> $onehot0(action_o) && action_o != 2'b00);

    p_alternate_r8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b11) && obstacle_i |-> action_o == 2'b10);
endmodule

bind turn_alternator turn_alternator_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .obstacle_i (obstacle_i),
    .action_o   (action_o),
    .state_o    (state_o)
);

// File: tb/turn_alternator_bench.sv
`timescale 1ns/1ps
module turn_alternator_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       obstacle_i = 1'b0;
    logic [1:0] action_o;
    logic [1:0] state_o;
    logic [1:0] ms;          // model state
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;    // 250 MHz

    turn_alternator u_turn_alternator (
        .clk        (clk),
        .rst        (rst),
        .obstacle_i (obstacle_i),
        .action_o   (action_o),
        .state_o    (state_o)
    );

    function automatic logic [1:0] model_next(input logic [1:0] s, input logic x);
        case (s)
            2'b00:   return x ? 2'b01 : 2'b00;
            2'b01:   return x ? 2'b01 : 2'b11;
            2'b11:   return x ? 2'b10 : 2'b11;
            default: return x ? 2'b10 : 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] model_act(input logic [1:0] s, input logic x);
        if (!x) return 2'b00;
        return s[1] ? 2'b10 : 2'b01;
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic string state_tag(input logic [1:0] s);
        case (s)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // Drive x at the falling edge, check the action mid-cycle, then the state after the edge.
    task automatic step(input logic x);
        @(negedge clk);
        obstacle_i = x;
        #0.5;
        check("R6", action_o, model_act(ms, x));
        @(posedge clk);
        #0.5;
        check(state_tag(ms), state_o, model_next(ms, x));
        ms = model_next(ms, x);
    endtask

    task automatic do_clear(input logic x);
        @(negedge clk);
        rst = 1'b1;
        obstacle_i = x;
        @(posedge clk);
        #0.5;
        check("R1", state_o, 2'b00);
        ms = 2'b00;
        @(negedge clk);
        rst = 1'b0;
        obstacle_i = 1'b0;
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        ms = 2'b00;
        repeat (3) @(posedge clk);
        #0.5;
        check("R1", state_o, 2'b00);
        @(negedge clk);
        rst = 1'b0;

        // Exhaustive: every state with both inputs; R2 R3 R4 R5 via step.
        for (int t = 0; t < 4; t++) begin
            for (int x = 0; x < 2; x++) begin
                do_clear(1'b0);
                if (t >= 1) step(1'b1);
                if (t >= 2) step(1'b0);
                if (t >= 3) step(1'b1);
                step(x[0]);
            end
        end

        // R1: clear wins over an obstacle, from the turning-right state.
        do_clear(1'b0);
        step(1'b1);
        do_clear(1'b1);

        // R7: the action follows the obstacle input inside one cycle.
        do_clear(1'b0);
        step(1'b1);
        step(1'b0);                 // now in clear-after-right
        @(negedge clk);
        obstacle_i = 1'b1;
        #0.5;
        check("R7", action_o, 2'b10);
        obstacle_i = 1'b0;
        #0.5;
        check("R7", action_o, 2'b00);
        @(posedge clk);
        #0.5;
        check("R7", state_o, 2'b11);

        // R8: episodes alternate, single-cycle and longer ones.
        do_clear(1'b0);
        begin
            logic [1:0] last_turn;
            last_turn = 2'b10;
            for (int e = 0; e < 6; e++) begin
                for (int k = 0; k <= e % 3; k++) begin
                    @(negedge clk);
                    obstacle_i = 1'b1;
                    #0.5;
                    check("R8", action_o, (last_turn == 2'b10) ? 2'b01 : 2'b10);
                    @(posedge clk);
                    ms = model_next(ms, 1'b1);
                end
                last_turn = (last_turn == 2'b10) ? 2'b01 : 2'b10;
                step(1'b0);
            end
        end

        // Pseudo-random walk against the model.
        do_clear(1'b0);
        begin
            logic [7:0] lf;
            lf = 8'h5a;
            for (int i = 0; i < 300; i++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                step(lf[0] & lf[2]);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule